// File: doc/BRIEF.md
# Sampling Window Centre Search

This block places a data sampling strobe in the middle of the valid data window. It starts from a nominal 4-bit sample-delay code. It then moves a clock-sampling strobe away from that point, first earlier and then later, one code step at a time. After every step it waits a programmable settle time and reads a one-bit check result. The check says whether the strobe still lands inside the correct cycle of the data clock. Because that clock is aligned with the data bits, the two places where the check drops mark the two edges of the data window.

The highest passing code on each side gives the reach of the window in that direction. The block moves the nominal code by half the difference between the two reaches. A host pulses `start`, drives the delay lines from the three code outputs, feeds the comparator result back on `check_bit`, and takes `opt_code` when `done` pulses. If the strobe already fails with no shift at all, the block raises `fail` instead of returning a result.

Top module: `win_center_search`

## Requirements
- R1: After reset, `busy`, `done` and `fail` are 0, and `left_code`, `right_code`, `nominal_code` and `opt_code` are all 0.
- R2: A `start` pulse while idle captures `nominal_in` and `settle_cycles`. `nominal_code` shows the captured value until the next accepted start. A `start` pulse while busy is ignored and changes neither the result nor the run time.
- R3: Each check sample is taken `settle_cycles`+1 clock cycles after the codes it judges were applied. The time from the clock edge that accepts `start` to the cycle in which `done` is high is therefore (number of samples) × (`settle_cycles`+1) cycles.
- R4: The first sample is taken with both shift codes at 0. If `check_bit` is 0 there, the run ends at once with `done`=1 and `fail`=1. `opt_code` then equals the captured nominal code, and neither shift code ever leaves 0.
- R5: Left sweep: with `right_code` held at 0, `left_code` steps up by 1 from 1. The sweep ends at the first failing sample, or after a passing sample at code 15. The left reach is the last passing code, which is 0 if code 1 fails.
- R6: Right sweep: after the left sweep, `left_code` returns to 0 and `right_code` steps up by 1 from 1. It ends and records the right reach under the same rule as R5.
- R7: `left_code` and `right_code` are never both nonzero, and both are 0 whenever the block is idle.
- R8: On success, `opt_code` = nominal + (right reach − left reach)/2. The halving rounds toward zero, so the result rounds toward the nominal code, and the sum saturates to the range 0..15.
- R9: `done` is a one-cycle pulse during which `busy` is already 0. `opt_code` holds its value until the next `done`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a search; accepted only when idle |
| nominal_in | input | 4 | Nominal sample-delay code captured at start |
| settle_cycles | input | 8 | Extra wait cycles after each code change, captured at start |
| check_bit | input | 1 | 1 = strobe lands in the correct clock cycle |
| busy | output | 1 | A search is in progress |
| done | output | 1 | One-cycle pulse when a search ends |
| fail | output | 1 | Valid with done: the check failed at zero shift |
| nominal_code | output | 4 | Captured nominal code that drives the sample delay |
| left_code | output | 4 | Shift code that moves the strobe earlier |
| right_code | output | 4 | Shift code that moves the strobe later |
| opt_code | output | 4 | Centred sample-delay code from the last search |

## Verification
The assertions check the code-stepping rules on every cycle. These are: the exclusivity of the two shift codes, steps of exactly +1 or a return to 0, a stable nominal code during a run, the single-cycle `done` pulse with `busy` low, and a fail result that equals the nominal code. The arithmetic of the centred code, its rounding toward the nominal and its saturation at both ends can only be shown by scenarios that place the window edges at chosen codes. The same holds for the exact settle latency and for the way a start pulse during a run is ignored. The scoreboard predicts these values from a window model and compares them against each completed search.

// File: rtl/wcs_pkg.sv
package wcs_pkg;
  typedef enum logic [1:0] {
    PH_IDLE  = 2'd0,
    PH_ZERO  = 2'd1,
    PH_LEFT  = 2'd2,
    PH_RIGHT = 2'd3
  } phase_t;
endpackage

// File: rtl/wcs_settle_timer.sv
module wcs_settle_timer #(
  parameter int unsigned CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  output logic             expired
);
  logic [CNT_W-1:0] cnt_q;
  logic             armed_q;

  assign expired = armed_q && (cnt_q == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q   <= '0;
      armed_q <= 1'b0;
    end else if (load) begin
      cnt_q   <= load_val;
      armed_q <= 1'b1;
    end else if (armed_q) begin
      if (cnt_q == '0) armed_q <= 1'b0;
      else             cnt_q   <= cnt_q - 1'b1;
    end
  end
endmodule

// File: rtl/wcs_center_calc.sv
module wcs_center_calc #(
  parameter int unsigned CODE_W = 4
) (
  input  logic [CODE_W-1:0] nom,
  input  logic [CODE_W-1:0] reach_l,
  input  logic [CODE_W-1:0] reach_r,
  output logic [CODE_W-1:0] centred
);
  localparam int unsigned SW = CODE_W + 2;

  function automatic logic [CODE_W-1:0] centre_of(
    input logic [CODE_W-1:0] n,
    input logic [CODE_W-1:0] l,
    input logic [CODE_W-1:0] r
  );
    logic signed [SW-1:0] diff, half, sum, top;
    diff = $signed({2'b00, r}) - $signed({2'b00, l});
    // halve with truncation toward zero => toward the nominal code
    if (diff < 0) half = -((-diff) >>> 1);
    else          half = diff >>> 1;
    sum = $signed({2'b00, n}) + half;
    top = $signed({2'b00, {CODE_W{1'b1}}});
    if (sum < 0)        return '0;
    else if (sum > top) return '1;
    else                return sum[CODE_W-1:0];
  endfunction

  assign centred = centre_of(nom, reach_l, reach_r);
endmodule

// File: rtl/win_center_search.sv
module win_center_search
  import wcs_pkg::*;
#(
  parameter int unsigned CODE_W   = 4,
  parameter int unsigned SETTLE_W = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                start,
  input  logic [CODE_W-1:0]   nominal_in,
  input  logic [SETTLE_W-1:0] settle_cycles,
  input  logic                check_bit,
  output logic                busy,
  output logic                done,
  output logic                fail,
  output logic [CODE_W-1:0]   nominal_code,
  output logic [CODE_W-1:0]   left_code,
  output logic [CODE_W-1:0]   right_code,
  output logic [CODE_W-1:0]   opt_code
);
  localparam logic [CODE_W-1:0] CODE_MAX = {CODE_W{1'b1}};
  localparam logic [CODE_W-1:0] CODE_ONE = {{(CODE_W-1){1'b0}}, 1'b1};

  phase_t              phase_q;
  logic [CODE_W-1:0]   nom_q, left_q, right_q, lreach_q, opt_q;
  logic [SETTLE_W-1:0] settle_q;
  logic                done_q, fail_q;

  // named internal events
  logic                start_acc;
  logic                sample_evt;
  logic                tmr_expired;
  logic                tmr_load;
  logic [SETTLE_W-1:0] tmr_val;
  logic [CODE_W-1:0]   cur_code;
  logic                at_limit;
  logic [CODE_W-1:0]   last_good;
  logic                sweep_goes_on;
  logic [CODE_W-1:0]   centre_res;

  assign start_acc  = (phase_q == PH_IDLE) && start;
  assign sample_evt = (phase_q != PH_IDLE) && tmr_expired;
  assign cur_code   = (phase_q == PH_LEFT) ? left_q : right_q;
  assign at_limit   = (cur_code == CODE_MAX);
  assign last_good  = check_bit ? cur_code : (cur_code - CODE_ONE);

  always_comb begin
    sweep_goes_on = 1'b0;
    unique case (phase_q)
      PH_ZERO:  sweep_goes_on = check_bit;
      PH_LEFT:  sweep_goes_on = 1'b1;
      PH_RIGHT: sweep_goes_on = check_bit && !at_limit;
      default:  sweep_goes_on = 1'b0;
    endcase
  end

  assign tmr_load = start_acc || (sample_evt && sweep_goes_on);
  assign tmr_val  = start_acc ? settle_cycles : settle_q;

  wcs_settle_timer #(.CNT_W(SETTLE_W)) u_timer (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (tmr_load),
    .load_val (tmr_val),
    .expired  (tmr_expired)
  );

  wcs_center_calc #(.CODE_W(CODE_W)) u_calc (
    .nom     (nom_q),
    .reach_l (lreach_q),
    .reach_r (last_good),
    .centred (centre_res)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q  <= PH_IDLE;
      nom_q    <= '0;
      settle_q <= '0;
      left_q   <= '0;
      right_q  <= '0;
      lreach_q <= '0;
      opt_q    <= '0;
      done_q   <= 1'b0;
      fail_q   <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (start_acc) begin
        nom_q    <= nominal_in;
        settle_q <= settle_cycles;
        left_q   <= '0;
        right_q  <= '0;
        fail_q   <= 1'b0;
        phase_q  <= PH_ZERO;
      end else if (sample_evt) begin
        unique case (phase_q)
          PH_ZERO: begin
            if (check_bit) begin
              left_q  <= CODE_ONE;
              phase_q <= PH_LEFT;
            end else begin
              opt_q   <= nom_q;
              fail_q  <= 1'b1;
              done_q  <= 1'b1;
              phase_q <= PH_IDLE;
            end
          end
          PH_LEFT: begin
            if (check_bit && !at_limit) begin
              left_q <= left_q + CODE_ONE;
            end else begin
              lreach_q <= last_good;
              left_q   <= '0;
              right_q  <= CODE_ONE;
              phase_q  <= PH_RIGHT;
            end
          end
          PH_RIGHT: begin
            if (check_bit && !at_limit) begin
              right_q <= right_q + CODE_ONE;
            end else begin
              opt_q   <= centre_res;
              right_q <= '0;
              done_q  <= 1'b1;
              phase_q <= PH_IDLE;
            end
          end
          default: phase_q <= PH_IDLE;
        endcase
      end
    end
  end

  assign busy         = (phase_q != PH_IDLE);
  assign done         = done_q;
  assign fail         = fail_q;
  assign nominal_code = nom_q;
  assign left_code    = left_q;
  assign right_code   = right_q;
  assign opt_code     = opt_q;
endmodule

// File: rtl/wcs_checker.sv
module wcs_checker #(
  parameter int unsigned CODE_W = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              busy,
  input logic              done,
  input logic              fail,
  input logic              sample_evt,
  input logic [CODE_W-1:0] nominal_code,
  input logic [CODE_W-1:0] left_code,
  input logic [CODE_W-1:0] right_code,
  input logic [CODE_W-1:0] opt_code
);
  // R7
  idle_codes_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (left_code == '0) && (right_code == '0));

  // R7
  shift_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !((left_code != '0) && (right_code != '0)));

  // R2
  nominal_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> $stable(nominal_code));

  // R4
  fail_keeps_nominal_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done && fail) |-> (opt_code == nominal_code));

  // R5
  left_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (left_code != $past(left_code)) |->
      ((left_code == CODE_W'($past(left_code) + 1'b1)) || (left_code == '0)));

  // R6
  right_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (right_code != $past(right_code)) |->
      ((right_code == CODE_W'($past(right_code) + 1'b1)) || (right_code == '0)));

  // R3
  code_moves_on_sample_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy) && !$past(sample_evt)) |->
      ($stable(left_code) && $stable(right_code)));

  // R9
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R9
  done_not_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);

  // R9
  opt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !done |-> $stable(opt_code));
endmodule

bind win_center_search wcs_checker #(.CODE_W(CODE_W)) u_wcs_checker (
  .clk          (clk),
  .rst_n        (rst_n),
  .busy         (busy),
  .done         (done),
  .fail         (fail),
  .sample_evt   (sample_evt),
  .nominal_code (nominal_code),
  .left_code    (left_code),
  .right_code   (right_code),
  .opt_code     (opt_code)
);

// File: tb/tb_win_center_search.sv
module tb_win_center_search;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       start = 1'b0;
  logic [3:0] nominal_in = '0;
  logic [7:0] settle_cycles = '0;
  logic       check_bit;
  logic       busy, done, fail;
  logic [3:0] nominal_code, left_code, right_code, opt_code;

  always #2.5 clk = ~clk;

  win_center_search dut (
    .clk(clk), .rst_n(rst_n), .start(start), .nominal_in(nominal_in),
    .settle_cycles(settle_cycles), .check_bit(check_bit), .busy(busy),
    .done(done), .fail(fail), .nominal_code(nominal_code),
    .left_code(left_code), .right_code(right_code), .opt_code(opt_code)
  );

  // window model: check passes while both shifts stay inside the window
  int win_l = 15, win_r = 15;
  bit zero_ok = 1'b1;
  assign check_bit = zero_ok && (int'(left_code) <= win_l) && (int'(right_code) <= win_r);

  typedef struct { int opt; bit fl; int lat; int maxl; int maxr; } exp_t;
  exp_t sb[$];

  int checks = 0, fails = 0;
  int cyc = 0, start_cyc = 0;
  int seen_l = 0, seen_r = 0;
  bit overlap = 1'b0;
  int last_opt = 0;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // monitor: tracks code excursions and pops the scoreboard on done
  always @(negedge clk) begin
    if (rst_n && busy) begin
      if (int'(left_code) > seen_l) seen_l = int'(left_code);
      if (int'(right_code) > seen_r) seen_r = int'(right_code);
      if (left_code != 0 && right_code != 0) overlap = 1'b1;
    end
    if (rst_n && done) begin
      exp_t e;
      if (sb.size() == 0) begin
        chk(1'b0, "R9 unexpected done", 1, 0);
      end else begin
        e = sb.pop_front();
        chk(int'(opt_code) == e.opt, "R8 opt_code", int'(opt_code), e.opt);
        chk(fail == e.fl, "R4 fail flag", int'(fail), int'(e.fl));
        chk(cyc - start_cyc == e.lat, "R3 latency", cyc - start_cyc, e.lat);
        chk(seen_l == e.maxl, "R5 highest left code", seen_l, e.maxl);
        chk(seen_r == e.maxr, "R6 highest right code", seen_r, e.maxr);
        chk(!overlap, "R7 shift codes overlap", int'(overlap), 0);
        chk(!busy, "R9 busy with done", int'(busy), 0);
        last_opt = e.opt;
      end
    end
  end

  function automatic int visits(input int reach);
    return (reach >= 15) ? 15 : reach + 1;
  endfunction

  function automatic int expect_centre(input int n, input int l, input int r);
    int d, h, s;
    d = r - l;
    h = (d >= 0) ? (d / 2) : -((-d) / 2);
    s = n + h;
    if (s < 0) s = 0;
    if (s > 15) s = 15;
    return s;
  endfunction

  task automatic run_case(input int nom, input int settle, input int wl, input int wr,
                          input bit zok, input bit poke);
    exp_t e;
    win_l = wl; win_r = wr; zero_ok = zok;
    if (zok) begin
      e.opt  = expect_centre(nom, wl, wr);
      e.fl   = 1'b0;
      e.lat  = (1 + visits(wl) + visits(wr)) * (settle + 1);
      e.maxl = visits(wl);
      e.maxr = visits(wr);
    end else begin
      e.opt = nom; e.fl = 1'b1; e.lat = settle + 1; e.maxl = 0; e.maxr = 0;
    end
    sb.push_back(e);
    @(negedge clk);
    nominal_in = 4'(nom); settle_cycles = 8'(settle);
    seen_l = 0; seen_r = 0; overlap = 1'b0;
    start = 1'b1;
    start_cyc = cyc + 1;
    @(negedge clk);
    start = 1'b0;
    chk(int'(nominal_code) == nom, "R2 captured nominal", int'(nominal_code), nom);
    if (poke) begin
      // R2: start while busy must be ignored
      repeat (3) @(negedge clk);
      nominal_in = ~nominal_in; settle_cycles = 8'd0; start = 1'b1;
      @(negedge clk);
      start = 1'b0;
    end
    while (sb.size() != 0) @(negedge clk);
    repeat (3) @(negedge clk);
    chk(int'(opt_code) == last_opt, "R9 opt_code held", int'(opt_code), last_opt);
    chk(done == 1'b0, "R9 done pulse length", int'(done), 0);
    chk(int'(nominal_code) == nom, "R2 nominal held after run", int'(nominal_code), nom);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(!busy && !done && !fail, "R1 status after reset", {busy, done, fail}, 0);
    chk(left_code == 0 && right_code == 0, "R1 shift codes after reset",
        int'({left_code, right_code}), 0);
    chk(opt_code == 0 && nominal_code == 0, "R1 codes after reset",
        int'({opt_code, nominal_code}), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!busy, "R1 idle after release", int'(busy), 0);

    run_case(8, 2, 5, 5, 1'b1, 1'b0);    // symmetric window
    run_case(8, 0, 2, 9, 1'b1, 1'b0);    // R8 +7 -> +3
    run_case(8, 1, 9, 2, 1'b1, 1'b0);    // R8 -7 -> -3 toward nominal
    run_case(14, 3, 0, 15, 1'b1, 1'b0);  // R8 saturate high, R5 left fails at 1
    run_case(1, 0, 15, 0, 1'b1, 1'b0);   // R8 saturate low, R5 left reaches 15
    run_case(6, 4, 7, 7, 1'b0, 1'b0);    // R4 zero-shift failure
    run_case(3, 5, 15, 15, 1'b1, 1'b1);  // R2 start during run ignored
    run_case(7, 0, 4, 7, 1'b1, 1'b0);    // R6 odd difference +3 -> +1

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    checks++; fails++;
    $display("FAIL R3 watchdog actual=timeout expected=done");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule